// File: doc/BRIEF.md
# Five-lane parallel digital downconversion mixer

This block mixes a fast ADC stream down to baseband when the converter delivers several samples per logic clock. Every clock it takes one wide word holding five consecutive signed 12-bit samples. It multiplies each sample by the matching phase of a complex local oscillator, and every clock it returns five I/Q product pairs. The logic can therefore run at one fifth of the sample rate, for example a 200 MHz clock for a 1 GS/s converter.

The oscillator is a 32-bit phase accumulator. On each clock it advances by five times the tuning word. Lane k of a word is given the word's base phase plus k tuning words, so the five lanes together reproduce exactly what a one-sample-per-clock oscillator running at the full rate would produce. Sine and cosine come from a quarter-wave lookup table. The pipeline has no iterative stage and has a fixed latency, so a new word can enter on every cycle. The outputs are intended for later halfband and CIC decimation stages, which lie outside this block. The only framing signal is a valid flag that travels with the data.

Top module: `ddc_mixer5`

## Requirements
- R1: in_data carries lane k (k = 0..4) in bits [12k+11:12k] as a two's-complement sample, and lane 0 is the oldest sample. out_i and out_q use the same lane order, with lane k in bits [16k+15:16k].
- R2: The 32-bit phase accumulator advances by 5 × tune_word (modulo 2^32) on every clock that is not in reset, whatever the value of in_valid.
- R3: The phase of lane k is P + k × W (modulo 2^32). P is the accumulator value before the edge that samples the word, and W is tune_word sampled at that same edge.
- R4: The oscillator amplitude at 10-bit phase index p (bits 31:22 of the lane phase) is round(32767 × sin(2πp/1024)) for sine. Cosine uses index (p+256) mod 1024. Rounding is to nearest, with ties rounded away from zero.
- R5: With x as the lane sample, I = floor((x × cos + 1024) / 2048) and Q = floor((−x × sin + 1024) / 2048). This is the product scaled down by 2^11 and rounded half up.
- R6: If in_valid and in_data are sampled at rising edge t, the result appears on out_i and out_q just after edge t+4, and out_valid then equals that in_valid.
- R7: Words can be accepted on back-to-back clocks indefinitely, with no stall and no gap.
- R8: A change of tune_word applies from the first word sampled with the new value. The phase continues from where the accumulator stood and is not reset.
- R9: A synchronous active-high rst clears the accumulator to zero and clears out_valid. The first word sampled after rst is released has a base phase of 0.
- R10: Every I and Q result lies within ±32767, full-scale samples included. Oscillator amplitudes never take the value −32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock, one fifth of the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_data as carrying samples |
| in_data | input | 60 | Five signed 12-bit samples, oldest in lane 0 |
| tune_word | input | 32 | Per-sample phase increment of the oscillator |
| out_valid | output | 1 | in_valid delayed to line up with the results |
| out_i | output | 80 | Five signed 16-bit in-phase products |
| out_q | output | 80 | Five signed 16-bit quadrature products |

## Verification
The bench builds the block with its default values: five lanes, 12-bit samples, a 10-bit phase table and 16-bit amplitudes. At this size every one of the 4096 sample codes can be passed through the mixer at zero tuning. A tuning word of one table step per sample also takes the lanes through all 1024 phase indices, which covers each quadrant fold and the indices at the quadrant edges. With these small widths, the bench can compute every lane of every word from the sine formula and a 32-bit accumulator of its own. This covers tuning changes made while running, gaps in in_valid, idle clocks and a reset in the middle of a stream.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    localparam int LANES       = 5;
    localparam int SAMP_W      = 12;
    localparam int PHASE_W     = 32;
    localparam int LUT_PHASE_W = 10;
    localparam int AMP_W       = 16;
    localparam int OUT_W       = 16;

    localparam real HALF_PI = 1.5707963267948966;

    // Quadrant of a table phase: decides mirroring of the index and sign.
    typedef enum logic [1:0] {
        QD_RISE     = 2'd0,
        QD_FALL     = 2'd1,
        QD_NEG_RISE = 2'd2,
        QD_NEG_FALL = 2'd3
    } quad_e;

    // One entry of the quarter-wave sine table, rounded to nearest.
    function automatic int quarter_amp(input int idx, input int qn, input int amax);
        real a;
        a = $sin(HALF_PI * idx / qn) * amax;
        return int'($floor(a + 0.5));
    endfunction

    // Right shift that maps a sample x amplitude product onto the output width.
    function automatic int product_shift(input int sw, input int aw, input int ow);
        return sw + aw - 1 - ow;
    endfunction

endpackage

// File: rtl/ddc_nco.sv
module ddc_nco
    import ddc_pkg::*;
#(
    parameter int NL  = LANES,
    parameter int PW  = PHASE_W,
    parameter int LPW = LUT_PHASE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PW-1:0]           step,
    output logic [NL-1:0][LPW-1:0]  lut_ph
);
    localparam logic [PW-1:0] WORD_MUL = PW'(NL);

    logic [PW-1:0] acc;
    logic [PW-1:0] base_s1;
    logic [PW-1:0] step_s1;
    logic [PW-1:0] lane_ph [NL];
    logic [1:0]    warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            warm <= '0;
        end else begin
            acc <= acc + WORD_MUL * step;
            if (warm != 2'd3) warm <= warm + 2'd1;
        end
        base_s1 <= acc;
        step_s1 <= step;
    end

    for (genvar k = 0; k < NL; k++) begin : g_lane
        always_ff @(posedge clk) begin
            lane_ph[k] <= base_s1 + PW'(k) * step_s1;
        end
        assign lut_ph[k] = lane_ph[k][PW-1 -: LPW];
    end

    // R9
    reset_base_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (lane_ph[0] == '0));

    if (NL > 1) begin : g_cont
        // R8
        phase_cont_chk: assert property (@(posedge clk) disable iff (rst)
            (warm == 2'd3) |-> (lane_ph[0] == $past(lane_ph[0])
                + WORD_MUL * ($past(lane_ph[1]) - $past(lane_ph[0]))));
    end

endmodule

// File: rtl/ddc_sincos.sv
module ddc_sincos
    import ddc_pkg::*;
#(
    parameter int LPW = LUT_PHASE_W,
    parameter int AW  = AMP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LPW-1:0]       ph,
    output logic signed [AW-1:0] cos_o,
    output logic signed [AW-1:0] nsin_o
);
    localparam int QB   = LPW - 2;
    localparam int QN   = 1 << QB;
    localparam int AMAX = (1 << (AW - 1)) - 1;
    localparam logic signed [AW-1:0] AMIN = {1'b1, {(AW-1){1'b0}}};

    logic signed [AW-1:0] qtab [0:QN];

    for (genvar i = 0; i <= QN; i++) begin : g_tab
        localparam int V = quarter_amp(i, QN, AMAX);
        assign qtab[i] = AW'(V);
    end

    function automatic logic signed [AW-1:0] lookup(input logic [LPW-1:0] p);
        quad_e                q;
        logic [QB:0]          idx;
        logic signed [AW-1:0] m;
        q = quad_e'(p[LPW-1 -: 2]);
        if (q == QD_FALL || q == QD_NEG_FALL)
            idx = (QB+1)'(QN) - {1'b0, p[QB-1:0]};
        else
            idx = {1'b0, p[QB-1:0]};
        m = qtab[idx];
        return (q == QD_NEG_RISE || q == QD_NEG_FALL) ? -m : m;
    endfunction

    always_ff @(posedge clk) begin
        cos_o  <= lookup(ph + LPW'(QN));
        nsin_o <= -lookup(ph);
    end

    // R10
    amp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cos_o != AMIN) && (nsin_o != AMIN));

    // R4
    zero_phase_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ph) == '0) |-> (cos_o == AW'(AMAX) && nsin_o == '0));

endmodule

// File: rtl/ddc_lane_mix.sv
module ddc_lane_mix
    import ddc_pkg::*;
#(
    parameter int SW = SAMP_W,
    parameter int AW = AMP_W,
    parameter int OW = OUT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [SW-1:0] x,
    input  logic signed [AW-1:0] c,
    input  logic signed [AW-1:0] ns,
    output logic signed [OW-1:0] i_o,
    output logic signed [OW-1:0] q_o
);
    localparam int PRW = SW + AW;
    localparam int SH  = product_shift(SW, AW, OW);
    localparam logic signed [PRW:0] HALF = (PRW+1)'(2 ** (SH - 1));

    logic signed [PRW-1:0] prod_i, prod_q;
    logic signed [PRW:0]   sum_i, sum_q;

    always_ff @(posedge clk) begin
        prod_i <= PRW'(x) * PRW'(c);
        prod_q <= PRW'(x) * PRW'(ns);
    end

    always_comb begin
        sum_i = (PRW+1)'(prod_i) + HALF;
        sum_q = (PRW+1)'(prod_q) + HALF;
    end

    always_ff @(posedge clk) begin
        i_o <= sum_i[SH +: OW];
        q_o <= sum_q[SH +: OW];
    end

    // R10
    round_fit_chk: assert property (@(posedge clk) disable iff (rst)
        ((&sum_i[PRW:SH+OW-1]) || !(|sum_i[PRW:SH+OW-1])) &&
        ((&sum_q[PRW:SH+OW-1]) || !(|sum_q[PRW:SH+OW-1])));

endmodule

// File: rtl/ddc_mixer5.sv
module ddc_mixer5
    import ddc_pkg::*;
#(
    parameter int NL  = LANES,
    parameter int SW  = SAMP_W,
    parameter int PW  = PHASE_W,
    parameter int LPW = LUT_PHASE_W,
    parameter int AW  = AMP_W,
    parameter int OW  = OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [NL*SW-1:0] in_data,
    input  logic [PW-1:0]    tune_word,
    output logic             out_valid,
    output logic [NL*OW-1:0] out_i,
    output logic [NL*OW-1:0] out_q
);
    localparam int LAT = 5;

    logic [NL-1:0][LPW-1:0] lut_ph;
    logic [NL*SW-1:0]       d1, d2, d3;
    logic [LAT-1:0]         vpipe;
    logic [2:0]             cyc;

    ddc_nco #(.NL(NL), .PW(PW), .LPW(LPW)) u_nco (
        .clk    (clk),
        .rst    (rst),
        .step   (tune_word),
        .lut_ph (lut_ph)
    );

    always_ff @(posedge clk) begin
        d1 <= in_data;
        d2 <= d1;
        d3 <= d2;
        if (rst) begin
            vpipe <= '0;
            cyc   <= '0;
        end else begin
            vpipe <= {vpipe[LAT-2:0], in_valid};
            if (cyc != 3'(LAT)) cyc <= cyc + 3'd1;
        end
    end

    assign out_valid = vpipe[LAT-1];

    for (genvar k = 0; k < NL; k++) begin : g_lane
        logic signed [AW-1:0] cos_a, nsin_a;

        ddc_sincos #(.LPW(LPW), .AW(AW)) u_sc (
            .clk    (clk),
            .rst    (rst),
            .ph     (lut_ph[k]),
            .cos_o  (cos_a),
            .nsin_o (nsin_a)
        );

        ddc_lane_mix #(.SW(SW), .AW(AW), .OW(OW)) u_mix (
            .clk (clk),
            .rst (rst),
            .x   ($signed(d3[k*SW +: SW])),
            .c   (cos_a),
            .ns  (nsin_a),
            .i_o (out_i[k*OW +: OW]),
            .q_o (out_q[k*OW +: OW])
        );
    end

    // R6
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3'(LAT)) |-> (out_valid == $past(in_valid, 5)));

endmodule

// File: tb/sim_ddc_mixer5.sv
module sim_ddc_mixer5;
    localparam int CLK_PERIOD = 10;
    localparam real TWO_PI = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [59:0] in_data = '0;
    logic [31:0] tune_word = '0;
    logic        out_valid;
    logic [79:0] out_i, out_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddc_mixer5 u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .tune_word(tune_word), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int          checks = 0;
    int          errors = 0;
    int          k = 0;
    logic [31:0] macc = '0;
    string       tag = "R9";
    logic        ev [8];
    int          ei [8][5];
    int          eq [8][5];

    function automatic int amp(input int p);
        real v;
        v = $sin(TWO_PI * p / 1024.0) * 32767.0;
        if (v < 0.0) return -int'($floor(-v + 0.5));
        return int'($floor(v + 0.5));
    endfunction

    function automatic int rnd(input longint pr);
        return int'((pr + 64'sd1024) >>> 11);
    endfunction

    function automatic logic [11:0] smp(input int w, input int l, input int salt);
        return 12'((w * 37 + l * 1013 + salt * 7919) ^ (w << 3) ^ (l << 9));
    endfunction

    task automatic check(input string what, input int lane, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s lane %0d: got %0d expected %0d", tag, what, lane, got, exp);
        end
    endtask

    task automatic step(input logic v, input logic [59:0] d, input logic [31:0] f, input logic r);
        int s;
        @(negedge clk);
        if (k >= 5) begin
            s = (k - 5) % 8;
            check("out_valid", 0, int'(out_valid), int'(ev[s]));
            if (ev[s]) begin
                for (int l = 0; l < 5; l++) begin
                    check("I", l, int'($signed(out_i[l*16 +: 16])), ei[s][l]);
                    check("Q", l, int'($signed(out_q[l*16 +: 16])), eq[s][l]);
                end
            end
        end
        s = k % 8;
        if (r) begin
            macc = '0;
            for (int j = 0; j < 5; j++) if (k - j >= 0) ev[(k - j) % 8] = 1'b0;
        end else begin
            ev[s] = v;
            for (int l = 0; l < 5; l++) begin
                logic [31:0] ph;
                int x, p;
                x  = int'($signed(d[l*12 +: 12]));
                ph = macc + 32'(l) * f;
                p  = int'(ph[31:22]);
                ei[s][l] = rnd(longint'(x) * amp((p + 256) % 1024));
                eq[s][l] = rnd(-longint'(x) * amp(p));
            end
            macc = macc + 32'd5 * f;
        end
        in_valid  = v;
        in_data   = d;
        tune_word = f;
        rst       = r;
        k++;
    endtask

    function automatic logic [59:0] word_of(input int w, input int salt);
        logic [59:0] d;
        for (int l = 0; l < 5; l++) d[l*12 +: 12] = smp(w, l, salt);
        return d;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] ftab [4];
        ftab[0] = 32'h0123_4567; ftab[1] = 32'h8000_0000;
        ftab[2] = 32'h0000_0001; ftab[3] = 32'hC3A5_0F11;

        // R9: reset state, out_valid must stay low
        tag = "R9";
        for (int w = 0; w < 8; w++) step(1'b1, '0, 32'h0, 1'b1);

        // R5 rounding with cos = 32767, sin = 0: every 12-bit sample code
        tag = "R5";
        for (int w = 0; w < 820; w++) begin
            logic [59:0] d;
            for (int l = 0; l < 5; l++) d[l*12 +: 12] = 12'((w * 5 + l) % 4096 + 2048);
            step(1'b1, d, 32'h0, 1'b0);
        end

        // R4: one table step per sample sweeps all 1024 phase indices
        tag = "R4";
        for (int w = 0; w < 210; w++) step(1'b1, {5{12'sd2047}}, 32'h0040_0000, 1'b0);

        // R1: distinct lane samples expose lane order
        tag = "R1";
        for (int w = 0; w < 40; w++) step(1'b1, word_of(w, 1), 32'h0123_4567, 1'b0);

        // R3: large tuning word, per-lane phase offsets wrap
        tag = "R3";
        for (int w = 0; w < 40; w++) step(1'b1, word_of(w, 2), 32'hFEDC_BA98, 1'b0);

        // R8: tuning changes while running
        tag = "R8";
        for (int w = 0; w < 60; w++) step(1'b1, word_of(w, 3), ftab[(w / 3) % 4], 1'b0);

        // R6: gaps in in_valid
        tag = "R6";
        for (int w = 0; w < 40; w++) step((w % 3) != 0, word_of(w, 4), 32'h1357_9BDF, 1'b0);

        // R2: accumulator keeps advancing while idle
        tag = "R2";
        for (int w = 0; w < 10; w++) step(1'b0, word_of(w, 5), 32'h0765_4321, 1'b0);
        for (int w = 0; w < 20; w++) step(1'b1, word_of(w, 6), 32'h0765_4321, 1'b0);

        // R7 and R10: back-to-back full-scale words at quarter rate
        tag = "R7";
        for (int w = 0; w < 40; w++)
            step(1'b1, (w % 2) ? {5{12'h800}} : {5{12'h7FF}}, 32'h4000_0000, 1'b0);
        tag = "R10";
        for (int w = 0; w < 40; w++)
            step(1'b1, (w % 2) ? {5{12'h800}} : {5{12'h7FF}}, 32'h2000_0000 + 32'(w), 1'b0);

        // R9: reset in the middle of a stream restarts phase at 0
        tag = "R9";
        for (int w = 0; w < 3; w++) step(1'b1, word_of(w, 7), 32'h0ABC_DEF1, 1'b0);
        for (int w = 0; w < 2; w++) step(1'b1, word_of(w, 8), 32'h0ABC_DEF1, 1'b1);
        for (int w = 0; w < 20; w++) step(1'b1, word_of(w, 9), 32'h0ABC_DEF1, 1'b0);

        tag = "R6";
        for (int w = 0; w < 8; w++) step(1'b0, '0, 32'h0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule